// File: doc/BRIEF.md
# Interrupt Interval Timer

This block is a down-counting timer that sits next to a local interrupt controller. Software programs it through a small register port: a timer entry holding an 8-bit vector, a mask flag and a mode flag; an initial count; and a divide configuration that picks a power-of-two prescale of the input clock. A fourth address returns the live current count.

Writing the initial count starts counting from that value straight away and restarts the prescaler phase. In one-shot mode the count runs down to zero and stays there. In periodic mode it wraps back to the initial count every initial-count-plus-one prescaled ticks. Each expiry that is not masked produces a single-cycle request that carries the programmed vector.

Top module: `intr_interval_timer`

## Requirements
- R1: After reset the timer entry reads 0x0001_0000 (masked, one-shot, vector 0). The initial count, the current count and the divide configuration all read 0.
- R2: The divide configuration (address 3) keeps only write bits 3, 1 and 0. It reads back as the written value AND 0xB.
- R3: The prescale shift is (code + 1) mod 8, where code = {cfg[3], cfg[1], cfg[0]}. After a load, the current count drops by one every 2^shift clocks. Example: cfg 0xB divides by 1, cfg 0x0 by 2 and cfg 0x8 by 32.
- R4: A write to the initial count (address 1) at clock edge W makes the current count read the written value after W. It also restarts the prescaler, so the first decrement happens at edge W + 2^shift.
- R5: In one-shot mode (entry bit 17 = 0) the count stops at zero. Exactly one expiry is produced, at the edge where the count goes from 1 to 0, which is edge W + N·2^shift.
- R6: In periodic mode (entry bit 17 = 1) the tick that finds the count at zero reloads it with the initial count and produces an expiry. Expiries fall at edges W + k·(N+1)·2^shift.
- R7: In periodic mode an initial count of zero produces no expiry, and the count stays at zero.
- R8: Entry bit 16 masks the timer. A masked expiry raises no request, and the count keeps running.
- R9: An unmasked expiry drives irq_valid high for one cycle. In that same cycle irq_vector carries entry bits 7:0.
- R10: A write to the timer entry takes effect at once. When a one-shot timer held at zero is switched to periodic with a nonzero initial count, the next tick reloads the count and produces an expiry.
- R11: The current count (address 2) is read-only. Writes to it have no effect on the count.
- R12: A write to the initial count on the same edge as an expiry takes priority. That expiry is dropped, and counting restarts from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address: 0 entry, 1 initial count, 2 current count, 3 divide configuration |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read address, same map as the write address |
| reg_rdata | output | 32 | Read data, combinational from reg_raddr |
| irq_valid | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector that goes with irq_valid |

## Verification
A periodic reload and a software reload of the initial count can land on the same clock edge. The bench provokes this by writing a fresh initial count on the exact edge where the periodic timer would wrap. The scoreboard holds only the expiries that follow the new load, so a request at the colliding edge is flagged as unexpected and a shifted later expiry is flagged as a mismatch. A second overlap is also exercised: a change of mode written while the count sits at zero, followed by the very next tick.

// File: rtl/intr_timer_pkg.sv
package intr_timer_pkg;
  localparam int CNT_W     = 32;
  localparam int VEC_W     = 8;
  localparam int SHIFT_W   = 3;
  localparam int PER_BIT   = 17;
  localparam int MASK_BIT  = 16;

  typedef enum logic [1:0] {
    A_ENTRY = 2'd0,
    A_INIT  = 2'd1,
    A_CUR   = 2'd2,
    A_DIV   = 2'd3
  } reg_addr_e;

  // three stored config bits {cfg3,cfg1,cfg0} form the code; shift = code+1 mod 8
  function automatic logic [SHIFT_W-1:0] shift_of(input logic [2:0] code);
    return code + 3'd1;
  endfunction
endpackage

// File: rtl/itm_prescaler.sv
module itm_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_d, lim;

  always_comb begin
    lim   = ~({PRE_W{1'b1}} << shift);
    tick  = ((pre_q & lim) == lim);
    pre_d = restart ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R4: after a restart the phase is zero, so a tick follows only for divide-by-1
  p_restart_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (tick == (shift == '0)));
endmodule

// File: rtl/itm_counter.sv
module itm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] init_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur,
  output logic             expire
);
  logic [CNT_W-1:0] cur_d;

  always_comb begin
    cur_d  = cur;
    expire = 1'b0;
    if (load) begin
      cur_d = load_val;
    end else if (tick) begin
      if (cur != '0) begin
        cur_d  = cur - 1'b1;
        expire = (cur == CNT_W'(1)) && !periodic;
      end else if (periodic && (init_val != '0)) begin
        cur_d  = init_val;
        expire = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= cur_d;
  end

  // R4: a load is visible on the next cycle
  p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur == $past(load_val)));
  // R3: the count moves only on a prescaled tick or a load
  p_step_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cur));
  // R5: one-shot count stays at zero
  p_oneshot_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !periodic && cur == '0) |=> (cur == '0));
  // R7: periodic reload never comes from a zero initial count
  p_zero_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> (cur != '0));
endmodule

// File: rtl/intr_interval_timer.sv
module intr_interval_timer
  import intr_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_waddr,
  input  logic [31:0]      reg_wdata,
  input  logic [1:0]       reg_raddr,
  output logic [31:0]      reg_rdata,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  // timer entry fields
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             mask_q, mask_d;
  logic             per_q, per_d;
  logic [CNT_W-1:0] init_q, init_d;
  logic [2:0]       code_q, code_d;   // {cfg3, cfg1, cfg0}
  logic             irqv_d;
  logic [VEC_W-1:0] irqvec_d;

  logic we_entry, we_init, we_div;
  logic tick, expire;
  logic [CNT_W-1:0] cur;
  logic [SHIFT_W-1:0] shift;

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[31:PER_BIT+1], reg_wdata[MASK_BIT-1:VEC_W], reg_wdata[2]};

  always_comb begin
    we_entry = reg_we && (reg_waddr == A_ENTRY);
    we_init  = reg_we && (reg_waddr == A_INIT);
    we_div   = reg_we && (reg_waddr == A_DIV);
    shift    = shift_of(code_q);

    vec_d  = we_entry ? reg_wdata[VEC_W-1:0] : vec_q;
    mask_d = we_entry ? reg_wdata[MASK_BIT]  : mask_q;
    per_d  = we_entry ? reg_wdata[PER_BIT]   : per_q;
    init_d = we_init  ? reg_wdata[CNT_W-1:0] : init_q;
    code_d = we_div   ? {reg_wdata[3], reg_wdata[1:0]} : code_q;

    irqv_d   = expire && !mask_q;
    irqvec_d = expire ? vec_q : irq_vector;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q      <= '0;
      mask_q     <= 1'b1;
      per_q      <= 1'b0;
      init_q     <= '0;
      code_q     <= '0;
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      vec_q      <= vec_d;
      mask_q     <= mask_d;
      per_q      <= per_d;
      init_q     <= init_d;
      code_q     <= code_d;
      irq_valid  <= irqv_d;
      irq_vector <= irqvec_d;
    end
  end

  itm_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (we_init),
    .shift   (shift),
    .tick    (tick)
  );

  itm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (we_init),
    .load_val (reg_wdata[CNT_W-1:0]),
    .init_val (init_q),
    .tick     (tick),
    .periodic (per_q),
    .cur      (cur),
    .expire   (expire)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      A_ENTRY: begin
        reg_rdata[VEC_W-1:0] = vec_q;
        reg_rdata[MASK_BIT]  = mask_q;
        reg_rdata[PER_BIT]   = per_q;
      end
      A_INIT:  reg_rdata[CNT_W-1:0] = init_q;
      A_CUR:   reg_rdata[CNT_W-1:0] = cur;
      default: reg_rdata = {28'd0, code_q[2], 1'b0, code_q[1:0]};
    endcase
  end

  // R8: no request leaves while the entry was masked
  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(mask_q));
  // R9: the request is a single-cycle pulse
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid);
  // R12: a software load on the edge drops any expiry of that edge
  p_load_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    we_init |=> !irq_valid);
endmodule

// File: tb/intr_interval_timer_tb.sv
module intr_interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_waddr;
  logic [31:0] reg_wdata;
  logic [1:0]  reg_raddr;
  logic [31:0] reg_rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  int exp_cyc[$];
  logic [7:0] exp_vec[$];
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  intr_interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: pops expected expiries and compares edge index and vector
  always @(negedge clk) begin
    if (rst_n === 1'b1 && irq_valid === 1'b1) begin
      irq_seen++;
      checks++;
      if (exp_cyc.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected request: actual edge=%0d vec=0x%02h expected none", cyc, irq_vector);
      end else begin
        int ec;
        logic [7:0] ev;
        ec = exp_cyc.pop_front();
        ev = exp_vec.pop_front();
        if (ec != cyc || ev !== irq_vector) begin
          errors++;
          $display("FAIL R9 expiry: actual edge=%0d vec=0x%02h expected edge=%0d vec=0x%02h",
                   cyc, irq_vector, ec, ev);
        end
      end
    end
  end

  // driver helpers: called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d, output int e);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    e = cyc + 1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wr0(input logic [1:0] a, input logic [31:0] d);
    int e;
    wr(a, d, e);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_raddr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_until(input int k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic expect_irq(input int e, input logic [7:0] v);
    exp_cyc.push_back(e);
    exp_vec.push_back(v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] v;
    int w, w2, vv, base;
    reg_we = 0; reg_waddr = 0; reg_wdata = 0; reg_raddr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 entry", v, 32'h0001_0000);
    rd(2'd1, v); chk("R1 init", v, 0);
    rd(2'd2, v); chk("R1 cur", v, 0);
    rd(2'd3, v); chk("R1 div", v, 0);

    // R2 divide configuration mask
    wr0(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R2 div mask", v, 32'hB);

    // R3 / R4 / R11 prescale and load, masked one-shot
    wr0(2'd0, 32'h0001_0000);
    wr0(2'd3, 32'h1);                 // code 1 -> shift 2 -> /4
    wr(2'd1, 10, w);
    wait_until(w);     rd(2'd2, v); chk("R4 load visible", v, 10);
    wait_until(w + 3); rd(2'd2, v); chk("R4 phase restart", v, 10);
    wait_until(w + 4); rd(2'd2, v); chk("R3 /4 first step", v, 9);
    wr0(2'd2, 32'h0000_FFFF);         // lands on edge w+5
    rd(2'd2, v); chk("R11 cur read-only", v, 9);
    wait_until(w + 13); rd(2'd2, v); chk("R3 /4 later", v, 7);
    wr0(2'd3, 32'hB);                 // /1
    wr(2'd1, 20, w);
    wait_until(w + 5); rd(2'd2, v); chk("R3 /1", v, 15);
    wr0(2'd3, 32'h8);                 // code 4 -> /32
    wr(2'd1, 3, w);
    wait_until(w + 31); rd(2'd2, v); chk("R3 /32 before", v, 3);
    wait_until(w + 32); rd(2'd2, v); chk("R3 /32 step", v, 2);

    // R5 / R9 one-shot expiry
    wr0(2'd1, 0);
    wr0(2'd0, 32'h0000_0042);
    wr0(2'd3, 32'h0);                 // /2
    wr(2'd1, 5, w);
    expect_irq(w + 10, 8'h42);
    wait_until(w + 9);  rd(2'd2, v); chk("R5 count one", v, 1);
    wait_until(w + 10); rd(2'd2, v); chk("R5 reaches zero", v, 0);
    wait_until(w + 40); rd(2'd2, v); chk("R5 held at zero", v, 0);

    // R8 masked periodic keeps counting, no request
    wr0(2'd1, 0);
    wr0(2'd0, 32'h0003_0011);
    wr0(2'd3, 32'hB);
    base = irq_seen;
    wr(2'd1, 2, w);
    wait_until(w + 1);  rd(2'd2, v); chk("R8 count runs", v, 1);
    wait_until(w + 20); chk("R8 no request", irq_seen - base, 0);
    wr0(2'd1, 0);

    // R7 periodic with zero initial count
    wr0(2'd0, 32'h0002_0099);
    base = irq_seen;
    repeat (40) @(negedge clk);
    chk("R7 no request", irq_seen - base, 0);
    rd(2'd2, v); chk("R7 count zero", v, 0);

    // R6 periodic wrap every N+1 ticks
    wr0(2'd0, 32'h0002_0077);
    wr(2'd1, 3, w);
    expect_irq(w + 4, 8'h77); expect_irq(w + 8, 8'h77); expect_irq(w + 12, 8'h77);
    wait_until(w + 12); rd(2'd2, v); chk("R6 reload value", v, 3);
    wait_until(w + 13);
    wr0(2'd1, 0);

    // R10 switch held one-shot to periodic
    wr0(2'd0, 32'h0000_0055);
    wr(2'd1, 2, w);
    expect_irq(w + 2, 8'h55);
    wait_until(w + 4);
    wr(2'd0, 32'h0002_0055, vv);
    expect_irq(vv + 1, 8'h55); expect_irq(vv + 4, 8'h55);
    wait_until(vv + 5);
    wr0(2'd1, 0);

    // R12 load collides with periodic wrap
    wr0(2'd0, 32'h0002_0066);
    wr(2'd1, 3, w);
    expect_irq(w + 4, 8'h66);
    wait_until(w + 7);
    wr(2'd1, 3, w2);                  // lands on edge w+8, the wrap edge
    chk("R12 collide edge", w2, w + 8);
    expect_irq(w2 + 4, 8'h66); expect_irq(w2 + 8, 8'h66);
    wait_until(w2 + 9);
    wr0(2'd1, 0);
    repeat (20) @(negedge clk);

    checks++;
    if (exp_cyc.size() != 0) begin
      errors++;
      $display("FAIL R9 missing expiries: actual=%0d pending expected=0", exp_cyc.size());
    end
    summary();
  end
endmodule